// File: doc/BRIEF.md
# Communication Area Initializer

This block prepares a host-memory communication area during the last step of a storage port's start-up handshake. When it gets a start pulse, it takes a snapshot of four things: the ring base address, the two ring sizes (each given as a base-2 logarithm) and the purge-interrupt request flag. It then issues a series of single-word writes through a simple request/acknowledge write master.

The writes come in two passes. The first pass fills the whole region with zero words: the interrupt header words just below the ring base, then the response ring, then the command ring. The second pass revisits every response-ring descriptor and writes it back with its ownership bit set. This hands all response slots to the port. The command descriptors stay zero, so they belong to the host.

The handshake state machine that issued the start sees one of two results. A one-cycle done pulse means success. A sticky error flag means the memory stopped answering.

Top module: `comm_area_init`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `wr_req` are all low.
- R2: A `start` pulse seen while the block is idle or in error is accepted. In the next cycle `busy` and `wr_req` are high, and the first write goes to the ring base minus the header size with data 0. Bit 0 of `ring_base` is treated as 0.
- R3: The header below the ring base is 8 bytes (4 words) when `purge_ie` is 1, and 4 bytes (2 words) when it is 0.
- R4: The clearing pass writes data 0x0000 to consecutive even byte addresses, one 16-bit word per write. It writes header_words + 2*(2^`rsp_len_log2` + 2^`cmd_len_log2`) words. Each descriptor is 4 bytes, and the response ring sits directly at the ring base.
- R5: After clearing, the block visits each response slot i in turn, for i from 0 to 2^`rsp_len_log2` - 1. It writes 0x0000 to address base+4i, then 0x8000 to address base+4i+2. The value 0x8000 is the ownership bit, bit 15 of descriptor word 1. The second pass writes no command-ring address.
- R6: `wr_req`, `wr_addr` and `wr_data` hold steady until `wr_ack` is high at a clock edge. Each acknowledgement completes exactly one word, and the next word can be presented in the following cycle.
- R7: `done` is high for exactly one cycle: the cycle after the edge that acknowledges the final write. `busy` is low in that same cycle.
- R8: If `wr_req` stays unacknowledged for ACK_TIMEOUT consecutive cycles (default 16), the sequence stops. `wr_req` drops, `err` rises, and `done` does not pulse. `err` stays high until the next accepted `start`.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running sequence and the values it captured are unchanged.
- R10: Addresses wrap modulo 2^ADDR_W. A ring base smaller than the header size places the header at the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin initialization (one-cycle pulse) |
| ring_base | input | ADDR_W | Byte address of response descriptor 0 |
| rsp_len_log2 | input | LEN_W | log2 of response ring slot count |
| cmd_len_log2 | input | LEN_W | log2 of command ring slot count |
| purge_ie | input | 1 | Purge interrupts requested (selects 8-byte header) |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write byte address (even) |
| wr_data | output | 16 | Write data word |
| wr_ack | input | 1 | Write accepted at this edge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky memory-timeout error |

## Verification
The block's results fall due at fixed cycles:
- **First write:** the first write request appears one cycle after the edge that samples `start`.
- **Following writes:** each later word appears one cycle after the edge carrying the previous acknowledgement.
- **Done:** `done` appears one cycle after the final acknowledgement and lasts one cycle.
- **Error:** `err` appears one cycle after the ACK_TIMEOUT-th unacknowledged request cycle.

The bench drives inputs and samples outputs only on falling edges. Its memory responder logs each word at the falling edge where it raises the acknowledgement. This makes the order of writes, the number of cycles `done` is high, and the count of cycles before a timeout all exact quantities, which the bench compares against values computed from the requirements. Acknowledge latencies of zero, one and two cycles check that the write sequence does not depend on memory speed.

// File: rtl/comm_init_pkg.sv
package comm_init_pkg;

    localparam int CI_WORD_W     = 16;
    localparam int CI_OWN_BIT    = 15;
    localparam int CI_DESC_BYTES = 4;
    localparam int CI_HDR_SHORT  = 4;
    localparam int CI_HDR_LONG   = 8;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_CLEAR  = 2'd1,
        S_PRESET = 2'd2,
        S_FAULT  = 2'd3
    } ci_state_e;

endpackage

// File: rtl/ci_geometry.sv
module ci_geometry
    import comm_init_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int LEN_W  = 3,
    parameter int CNT_W  = 11
) (
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [LEN_W-1:0]  rsp_len_log2,
    input  logic [LEN_W-1:0]  cmd_len_log2,
    input  logic              purge_ie,
    output logic [ADDR_W-1:0] base_aligned,
    output logic [ADDR_W-1:0] clear_start,
    output logic [CNT_W-1:0]  clear_words,
    output logic [CNT_W-1:0]  rsp_words
);

    localparam int DESC_WORDS = CI_DESC_BYTES / 2;

    logic [CNT_W-1:0] rsp_slots;
    logic [CNT_W-1:0] cmd_slots;
    logic [CNT_W-1:0] hdr_words;

    always_comb begin
        base_aligned = {ring_base[ADDR_W-1:1], 1'b0};
        rsp_slots    = CNT_W'(1) << rsp_len_log2;
        cmd_slots    = CNT_W'(1) << cmd_len_log2;
        hdr_words    = purge_ie ? CNT_W'(CI_HDR_LONG / 2) : CNT_W'(CI_HDR_SHORT / 2);
        clear_start  = base_aligned - (purge_ie ? ADDR_W'(CI_HDR_LONG) : ADDR_W'(CI_HDR_SHORT));
        clear_words  = hdr_words + CNT_W'(DESC_WORDS) * (rsp_slots + cmd_slots);
        rsp_words    = CNT_W'(DESC_WORDS) * rsp_slots;
    end

endmodule

// File: rtl/ci_ack_timer.sv
module ci_ack_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ack,
    output logic expired
);

    localparam int TMR_W = $clog2(LIMIT + 1);

    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = req && !ack && (cnt_q == TMR_W'(LIMIT - 1));
        if (!req || ack || expired) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < TMR_W'(LIMIT)) else $error("timer beyond limit"); // R8

    AST_TMR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> cnt_q == '0) else $error("timer not cleared by ack"); // R8

endmodule

// File: rtl/ci_seq.sv
module ci_seq
    import comm_init_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    base_aligned,
    input  logic [ADDR_W-1:0]    clear_start,
    input  logic [CNT_W-1:0]     clear_words,
    input  logic [CNT_W-1:0]     rsp_words,
    input  logic                 expired,
    input  logic                 wr_ack,
    output logic                 wr_req,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [CI_WORD_W-1:0] wr_data,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);

    typedef struct packed {
        ci_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  remain;
        logic [CNT_W-1:0]  rsp_words;
        logic              phase;
        logic              done;
    } seq_t;

    localparam logic [CI_WORD_W-1:0] OWN_WORD = CI_WORD_W'(1) << CI_OWN_BIT;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.state)
            S_IDLE, S_FAULT: begin
                if (start) begin
                    s_d.state     = S_CLEAR;
                    s_d.addr      = clear_start;
                    s_d.base      = base_aligned;
                    s_d.remain    = clear_words;
                    s_d.rsp_words = rsp_words;
                    s_d.phase     = 1'b0;
                end
            end
            S_CLEAR: begin
                if (expired) begin
                    s_d.state = S_FAULT;
                end else if (wr_ack) begin
                    if (s_q.remain == CNT_W'(1)) begin
                        s_d.state  = S_PRESET;
                        s_d.addr   = s_q.base;
                        s_d.remain = s_q.rsp_words;
                        s_d.phase  = 1'b0;
                    end else begin
                        s_d.addr   = s_q.addr + ADDR_W'(2);
                        s_d.remain = s_q.remain - CNT_W'(1);
                    end
                end
            end
            S_PRESET: begin
                if (expired) begin
                    s_d.state = S_FAULT;
                end else if (wr_ack) begin
                    if (s_q.remain == CNT_W'(1)) begin
                        s_d.state = S_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.addr   = s_q.addr + ADDR_W'(2);
                        s_d.remain = s_q.remain - CNT_W'(1);
                        s_d.phase  = ~s_q.phase;
                    end
                end
            end
            default: s_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: S_IDLE, addr: '0, base: '0, remain: '0,
                     rsp_words: '0, phase: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        wr_req  = (s_q.state == S_CLEAR) || (s_q.state == S_PRESET);
        wr_addr = s_q.addr;
        wr_data = ((s_q.state == S_PRESET) && s_q.phase) ? OWN_WORD : '0;
        busy    = wr_req;
        done    = s_q.done;
        err     = (s_q.state == S_FAULT);
    end

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && !expired) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)))
        else $error("request dropped or changed before ack"); // R6

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R7

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(wr_ack) && $past(wr_req) && !busy))
        else $error("done without final ack"); // R7

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!wr_req && !done)) else $error("activity while in error"); // R8

    AST_CLEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == S_CLEAR && wr_ack && s_q.remain != CNT_W'(1))
        |=> (wr_addr == ADDR_W'($past(wr_addr) + ADDR_W'(2)) && wr_data == '0))
        else $error("clear pass not sequential"); // R4

    AST_PRESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == S_CLEAR && wr_ack && s_q.remain == CNT_W'(1))
        |=> (wr_req && wr_addr == s_q.base && wr_data == '0))
        else $error("preset pass did not start at base"); // R5

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !wr_ack && !expired) |=> ($stable(s_q.remain) && $stable(s_q.base)))
        else $error("start while busy disturbed the sequence"); // R9

endmodule

// File: rtl/comm_area_init.sv
module comm_area_init
    import comm_init_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int LEN_W       = 3,
    parameter int ACK_TIMEOUT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    ring_base,
    input  logic [LEN_W-1:0]     rsp_len_log2,
    input  logic [LEN_W-1:0]     cmd_len_log2,
    input  logic                 purge_ie,
    output logic                 wr_req,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [CI_WORD_W-1:0] wr_data,
    input  logic                 wr_ack,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);

    localparam int MAX_SLOTS = 1 << ((1 << LEN_W) - 1);
    localparam int MAX_WORDS = (CI_HDR_LONG / 2) + 2 * (CI_DESC_BYTES / 2) * MAX_SLOTS;
    localparam int CNT_W     = $clog2(MAX_WORDS) + 1;

    logic [ADDR_W-1:0] base_aligned;
    logic [ADDR_W-1:0] clear_start;
    logic [CNT_W-1:0]  clear_words;
    logic [CNT_W-1:0]  rsp_words;
    logic              expired;

    ci_geometry #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W)
    ) i_geometry (
        .ring_base    (ring_base),
        .rsp_len_log2 (rsp_len_log2),
        .cmd_len_log2 (cmd_len_log2),
        .purge_ie     (purge_ie),
        .base_aligned (base_aligned),
        .clear_start  (clear_start),
        .clear_words  (clear_words),
        .rsp_words    (rsp_words)
    );

    ci_ack_timer #(
        .LIMIT (ACK_TIMEOUT)
    ) i_ack_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (wr_req),
        .ack     (wr_ack),
        .expired (expired)
    );

    ci_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .base_aligned (base_aligned),
        .clear_start  (clear_start),
        .clear_words  (clear_words),
        .rsp_words    (rsp_words),
        .expired      (expired),
        .wr_ack       (wr_ack),
        .wr_req       (wr_req),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .busy         (busy),
        .done         (done),
        .err          (err)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !err && !wr_req))
        else $error("outputs active after reset"); // R1

    AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !wr_addr[0]) else $error("odd write address"); // R4

endmodule

// File: tb/test_comm_area_init.sv
module test_comm_area_init;

    localparam int ADDR_W = 18;
    localparam int LEN_W  = 3;
    localparam int TMO    = 16;
    localparam int LOG_SZ = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] ring_base = '0;
    logic [LEN_W-1:0]  rsp_len_log2 = '0;
    logic [LEN_W-1:0]  cmd_len_log2 = '0;
    logic              purge_ie = 1'b0;
    logic              wr_req;
    logic [ADDR_W-1:0] wr_addr;
    logic [15:0]       wr_data;
    logic              wr_ack = 1'b0;
    logic              busy, done, err;

    always #2.5 clk = ~clk;

    comm_area_init #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ACK_TIMEOUT(TMO)) i_comm_area_init (
        .clk(clk), .rst_n(rst_n), .start(start), .ring_base(ring_base),
        .rsp_len_log2(rsp_len_log2), .cmd_len_log2(cmd_len_log2), .purge_ie(purge_ie),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .busy(busy), .done(done), .err(err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // memory responder
    int                resp_lat = 0;
    bit                resp_dead = 1'b0;
    int                wait_cnt = 0;
    logic [ADDR_W-1:0] log_addr [LOG_SZ];
    logic [15:0]       log_data [LOG_SZ];
    int                log_n = 0;
    bit                hold_v = 1'b0;
    logic [ADDR_W-1:0] hold_a = '0;
    logic [15:0]       hold_d = '0;
    int                stab_err = 0;

    always @(negedge clk) begin
        cycles++;
        if (wr_req) begin
            if (hold_v && (wr_addr != hold_a || wr_data != hold_d)) stab_err++;
            hold_v = 1'b1;
            hold_a = wr_addr;
            hold_d = wr_data;
            if (!resp_dead && wait_cnt >= resp_lat) begin
                wr_ack <= 1'b1;
                if (log_n < LOG_SZ) begin
                    log_addr[log_n] = wr_addr;
                    log_data[log_n] = wr_data;
                end
                log_n++;
                wait_cnt = 0;
                hold_v = 1'b0;
            end else begin
                wr_ack <= 1'b0;
                wait_cnt++;
            end
        end else begin
            wr_ack <= 1'b0;
            wait_cnt = 0;
            hold_v = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
            finish_run();
        end
    end

    task automatic set_inputs(input int r, input int c, input int p, input logic [ADDR_W-1:0] b);
        rsp_len_log2 = LEN_W'(r);
        cmd_len_log2 = LEN_W'(c);
        purge_ie     = p[0];
        ring_base    = b;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // compare the logged writes against the sequence built from R3/R4/R5/R10
    task automatic compare_log(input int r, input int c, input int p,
                               input logic [ADDR_W-1:0] b, input string tag);
        logic [ADDR_W-1:0] base_al = {b[ADDR_W-1:1], 1'b0};
        int hdr = p ? 8 : 4;
        int n_clr = hdr / 2 + 2 * ((1 << r) + (1 << c));
        int n_pre = 2 * (1 << r);
        chk(log_n == n_clr + n_pre, "R4", {tag, " word count"}, log_n, n_clr + n_pre);
        for (int i = 0; i < n_clr + n_pre && i < log_n && i < LOG_SZ; i++) begin
            logic [ADDR_W-1:0] ea;
            logic [15:0]       ed;
            if (i < n_clr) begin
                ea = ADDR_W'(base_al - ADDR_W'(hdr) + ADDR_W'(2 * i));
                ed = 16'h0000;
                chk(log_addr[i] == ea && log_data[i] == ed, "R4",
                    {tag, " clear word"}, {log_addr[i], log_data[i]}, {ea, ed});
            end else begin
                int j = i - n_clr;
                ea = ADDR_W'(base_al + ADDR_W'(2 * j));
                ed = (j % 2 == 1) ? 16'h8000 : 16'h0000;
                chk(log_addr[i] == ea && log_data[i] == ed, "R5",
                    {tag, " preset word"}, {log_addr[i], log_data[i]}, {ea, ed});
            end
        end
        chk(stab_err == 0, "R6", {tag, " request stability"}, stab_err, 0);
    endtask

    task automatic wait_end(output int done_cycles);
        int guard = 0;
        done_cycles = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        if (done) done_cycles++;
        @(negedge clk);
        if (done) done_cycles++;
    endtask

    task automatic t_run(input int r, input int c, input int p,
                         input logic [ADDR_W-1:0] b, input int lat, input string tag);
        int dc;
        resp_lat = lat;
        resp_dead = 1'b0;
        log_n = 0;
        stab_err = 0;
        set_inputs(r, c, p, b);
        pulse_start();
        chk(busy && wr_req, "R2", {tag, " busy after start"}, {busy, wr_req}, 2'b11);
        chk(wr_addr == ADDR_W'({b[ADDR_W-1:1], 1'b0} - ADDR_W'(p ? 8 : 4)), "R3",
            {tag, " first address"}, wr_addr,
            ADDR_W'({b[ADDR_W-1:1], 1'b0} - ADDR_W'(p ? 8 : 4)));
        wait_end(dc);
        chk(dc == 1, "R7", {tag, " done pulse width"}, dc, 1);
        chk(!busy && !err, "R7", {tag, " idle after done"}, {busy, err}, 0);
        compare_log(r, c, p, b, tag);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !err && !wr_req, "R1", "reset outputs",
            {busy, done, err, wr_req}, 0);
    endtask

    task automatic t_busy_start();
        int dc;
        resp_lat = 1;
        resp_dead = 1'b0;
        log_n = 0;
        stab_err = 0;
        set_inputs(1, 2, 0, 18'h00400);
        pulse_start();
        repeat (4) @(negedge clk);
        set_inputs(3, 3, 1, 18'h01000);
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_start();
        set_inputs(1, 2, 0, 18'h00400);
        wait_end(dc);
        chk(dc == 1, "R9", "done once with restarts ignored", dc, 1);
        compare_log(1, 2, 0, 18'h00400, "R9 busy-start");
    endtask

    task automatic t_timeout();
        int req_cycles = 0;
        int saw_done = 0;
        int guard = 0;
        resp_dead = 1'b1;
        log_n = 0;
        set_inputs(0, 1, 1, 18'h00800);
        pulse_start();
        while (!err && guard < 200) begin
            if (wr_req) req_cycles++;
            if (done) saw_done++;
            @(negedge clk);
            guard++;
        end
        chk(req_cycles == TMO, "R8", "unacked request cycles", req_cycles, TMO);
        chk(err && !wr_req && !busy, "R8", "error state", {err, wr_req, busy}, 3'b100);
        chk(saw_done == 0 && !done, "R8", "no done on error", saw_done, 0);
        repeat (3) @(negedge clk);
        chk(err, "R8", "error sticky", err, 1);
        resp_dead = 1'b0;
        t_run(0, 1, 1, 18'h00800, 0, "R8 restart after error");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run(0, 0, 0, 18'h01000, 0, "R3 short header");
        t_run(2, 1, 1, 18'h02347, 1, "R2 odd base long header");
        t_run(3, 3, 0, 18'h00002, 2, "R10 wrap below zero");
        t_run(7, 7, 1, 18'h10000, 0, "R5 largest rings");
        t_run(1, 0, 1, 18'h00006, 0, "R10 wrap long header");
        t_busy_start();
        t_timeout();
        finish_run();
    end

endmodule